// File: doc/BRIEF.md
# Temperature Event Alarm Controller

This block watches a stream of signed temperature samples and raises an active-low event line when a sample leaves a programmed window or passes a critical trip point. Each sample arrives as a parallel word with a one-cycle valid strobe. Four write-only registers hold the limits and a configuration word, and they are loaded through a simple address/data write port. The event line follows open-drain convention: low means asserted and high means released.

Three condition flags follow the samples: above the upper bound, below the lower bound, and above the critical point. Each flag sets as soon as a sample passes its limit. It releases only after the temperature has come back past the limit by a selectable hysteresis margin. The configuration chooses how the flags reach the event line. Compare mode follows the flags directly. Interrupt mode latches a window crossing until software clears it. Critical-only mode listens to the critical flag alone. In every mode the critical flag acts as a comparator that software cannot clear. A sticky lock bit protects the critical limit from later writes until reset.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `evt_n` is 1 and `cond_status` is 0. Upper and critical limits reset to +4095 LSB, the lower limit resets to -4096 LSB, the configuration resets to all zero, and the lock is clear.
- R2: Condition flags change only on a clock edge where `smp_valid` is 1. `smp_temp` is ignored at all other times.
- R3: The above flag (`cond_status[0]`) sets when a sample is greater than the upper limit. Once set, it clears when a sample is less than or equal to upper limit minus hysteresis.
- R4: The below flag (`cond_status[1]`) sets when a sample is less than the lower limit. Once set, it clears when a sample is greater than or equal to lower limit plus hysteresis.
- R5: The critical flag (`cond_status[2]`) sets when a sample is greater than the critical limit. Once set, it clears when a sample is less than or equal to critical limit minus hysteresis.
- R6: Temperatures and limits are 13-bit two's complement values with 1 LSB = 0.0625 °C. The hysteresis code in configuration bits [5:4] selects 0, 24, 48 or 96 LSB for codes 0, 1, 2 and 3.
- R7: In compare mode (configuration bit1 = 0, bit2 = 0), the event is active whenever the critical flag is set, or the window is enabled (bit3) and the above or below flag is set. A clear strobe has no effect in this mode.
- R8: In interrupt mode (bit1 = 1, bit2 = 0) with the window enabled, a sample that newly sets the above or below flag latches the event. The latch holds after the temperature returns inside the window and releases only on a clear strobe. A crossing while the window is disabled does not latch.
- R9: The critical flag drives the event as a comparator in every mode. A clear strobe cannot release an event while the critical flag is set.
- R10: In critical-only mode (bit2 = 1), only the critical flag drives the event. Window flags and clear strobes have no effect.
- R11: Configuration bit0 enables the event output. When it is 0, `evt_n` is 1 regardless of the flags.
- R12: Writing configuration bit7 = 1 sets a lock that only reset clears. While the lock is set, writes to the critical limit are ignored.
- R13: Register address 0 is configuration, 1 is upper limit, 2 is lower limit and 3 is critical limit. Writes take effect at the clock edge where `wr_en` is 1. Configuration bit6 is a one-cycle clear strobe and is not stored. A sample and a write on the same edge compare against the limits held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Temperature sample strobe |
| smp_temp | input | 13 | Signed temperature sample, 0.0625 °C per LSB |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select |
| wr_data | input | 13 | Register write data |
| evt_n | output | 1 | Event line, active low |
| cond_status | output | 3 | {critical, below, above} condition flags |

## Verification
The assertions assume the write port and sample inputs are known, single-cycle and stable around each rising edge once reset is released. They also assume the limits are programmed as two's complement values. Hysteresis arithmetic runs one bit wider, so limits near the range ends do not wrap. The stimulus changes inputs only on the falling edge and holds reset low from time zero. It uses limits where upper minus hysteresis stays above lower plus hysteresis, so each flag's set and release points are separate thresholds. A behavioural model in the bench follows every edge, including clears that coincide with samples.

// File: rtl/temp_alarm_pkg.sv
// Shared types and helpers for the temperature alarm controller.
// Assumes the 2-bit hysteresis code maps to 0, 1.5, 3 and 6 degC in 1/16 degC units.
package temp_alarm_pkg;

    localparam int HW = 7;  // width of a hysteresis amount in LSB

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_LOWER = 2'd2,
        SEL_CRIT  = 2'd3
    } reg_sel_e;

    // Stored configuration: the clear strobe and the lock request are decoded separately.
    typedef struct packed {
        logic [1:0] hyst;
        logic       win_en;
        logic       crit_only;
        logic       int_mode;
        logic       evt_en;
    } cfg_t;

    // Hysteresis code to LSB count: 0, 24, 48, 96.
    function automatic logic [HW-1:0] hyst_lsb(input logic [1:0] code);
        return (code == 2'd0) ? '0 : (HW'(12) << code);
    endfunction

endpackage

// File: rtl/temp_alarm_regs.sv
// Register file for the alarm controller: configuration, three limits and a sticky lock.
// Assumes wr_data holds at least 8 bits; the clear strobe is a single-cycle output.
module temp_alarm_regs
    import temp_alarm_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [TW-1:0]        wr_data,
    output cfg_t                 cfg_q,
    output logic                 lock_q,
    output logic signed [TW-1:0] upper_q,
    output logic signed [TW-1:0] lower_q,
    output logic signed [TW-1:0] crit_q,
    output logic                 clr_p
);
    localparam logic [TW-1:0] LIM_MAX = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] LIM_MIN = {1'b1, {(TW-1){1'b0}}};

    reg_sel_e sel;
    logic     cfg_wr;
    logic     unused_hi_bits;

    assign sel            = reg_sel_e'(wr_addr);
    assign cfg_wr         = wr_en && (sel == SEL_CFG);
    assign clr_p          = cfg_wr && wr_data[6];
    assign unused_hi_bits = ^wr_data[TW-1:8];

    // Register updates: limits, configuration, and the lock that only reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            lock_q  <= 1'b0;
            upper_q <= LIM_MAX;
            lower_q <= LIM_MIN;
            crit_q  <= LIM_MAX;
        end else if (wr_en) begin
            case (sel)
                SEL_CFG: begin
                    cfg_q <= cfg_t'(wr_data[5:0]);
                    if (wr_data[7]) lock_q <= 1'b1;
                end
                SEL_UPPER: upper_q <= wr_data;
                SEL_LOWER: lower_q <= wr_data;
                SEL_CRIT:  if (!lock_q) crit_q <= wr_data;
                default:   ;
            endcase
        end
    end

    // R12: a locked critical limit keeps its value across a write to it.
    a_r12_lock_blocks_crit: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_en && wr_addr == 2'd3) |=> (crit_q == $past(crit_q)));

    // R12: once set, the lock stays set until reset.
    a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

endmodule

// File: rtl/temp_alarm_cond.sv
// One threshold tracker with hysteresis. LOW_SIDE picks a below-limit tracker;
// otherwise it tracks above-limit. Comparisons run one bit wider than the data.
// Assumes the hysteresis amount is narrower than the temperature word.
module temp_alarm_cond
    import temp_alarm_pkg::*;
#(
    parameter int TW       = 13,
    parameter bit LOW_SIDE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [TW-1:0] smp_temp,
    input  logic signed [TW-1:0] limit,
    input  logic [HW-1:0]        hyst,
    output logic                 flag_q,
    output logic                 rise
);
    logic signed [TW:0] t_x, l_x, h_x, rel_lim;
    logic trip, release_ok;

    assign t_x = {smp_temp[TW-1], smp_temp};
    assign l_x = {limit[TW-1], limit};
    assign h_x = {{(TW+1-HW){1'b0}}, hyst};

    // Direction-specific set and release comparisons.
    generate
        if (LOW_SIDE) begin : g_low
            assign rel_lim    = l_x + h_x;
            assign trip       = t_x < l_x;
            assign release_ok = t_x >= rel_lim;
        end else begin : g_high
            assign rel_lim    = l_x - h_x;
            assign trip       = t_x > l_x;
            assign release_ok = t_x <= rel_lim;
        end
    endgenerate

    assign rise = smp_valid && !flag_q && trip;

    // Flag update, evaluated only on a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (smp_valid) flag_q <= flag_q ? !release_ok : trip;
    end

    // R2: without a sample, the flag holds.
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(flag_q));

    generate
        if (LOW_SIDE) begin : g_chk_low
            // R4: a sample under the lower limit leaves the flag set.
            a_r4_below_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_valid && smp_temp < limit) |=> flag_q);
        end else begin : g_chk_high
            // R3 and R5: a sample over the limit leaves the flag set.
            a_r3_r5_over_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_valid && smp_temp > limit) |=> flag_q);
        end
    endgenerate

endmodule

// File: rtl/temp_alarm_event.sv
// Event output logic: compare, interrupt and critical-only behaviour.
// Assumes rise inputs pulse only on the sample edge that newly sets a flag.
module temp_alarm_event (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_en,
    input  logic int_mode,
    input  logic crit_only,
    input  logic win_en,
    input  logic clr_p,
    input  logic above,
    input  logic below,
    input  logic crit,
    input  logic above_rise,
    input  logic below_rise,
    output logic evt_n
);
    logic lat_q, lat_set, win_src, evt_act;

    assign lat_set = win_en && (above_rise || below_rise);

    // Interrupt latch: set by a new window crossing; a set beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lat_q <= 1'b0;
        else if (int_mode && !crit_only)    lat_q <= lat_set || (lat_q && !clr_p);
        else                                lat_q <= 1'b0;
    end

    assign win_src = int_mode ? lat_q : (win_en && (above || below));
    assign evt_act = crit_only ? crit : (crit || win_src);
    assign evt_n   = !(evt_en && evt_act);

    // R9: a set critical flag always pulls the enabled event low.
    a_r9_crit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en && crit) |-> !evt_n);

    // R11: a disabled event output stays released.
    a_r11_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_en |-> evt_n);

    // R10: in critical-only mode, no critical flag means no event.
    a_r10_only_crit: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_only && !crit) |-> evt_n);

    // R8: the interrupt latch holds without a clear.
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !clr_p && int_mode && !crit_only) |=> lat_q);

endmodule

// File: rtl/temp_alarm_ctrl.sv
// Top of the temperature alarm controller: registers, three threshold trackers
// (above, below, critical) and the event logic. Assumes one sample per valid strobe.
module temp_alarm_ctrl
    import temp_alarm_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [TW-1:0] smp_temp,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    output logic          evt_n,
    output logic [2:0]    cond_status
);
    localparam int NCOND = 3;

    cfg_t                 cfg;
    logic                 lock, clr_p;
    logic signed [TW-1:0] lim [NCOND];
    logic [NCOND-1:0]     flags, rises;
    logic [HW-1:0]        hyst_amt;
    logic                 unused_crit_rise;

    temp_alarm_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_q(cfg), .lock_q(lock), .upper_q(lim[0]), .lower_q(lim[1]), .crit_q(lim[2]),
        .clr_p(clr_p)
    );

    assign hyst_amt = hyst_lsb(cfg.hyst);

    // One tracker per condition; index 1 (lower bound) is the low-side variant.
    generate
        for (genvar gi = 0; gi < NCOND; gi++) begin : g_cond
            temp_alarm_cond #(.TW(TW), .LOW_SIDE(gi == 1)) u_cond (
                .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
                .smp_temp(smp_temp), .limit(lim[gi]), .hyst(hyst_amt),
                .flag_q(flags[gi]), .rise(rises[gi])
            );
        end
    endgenerate

    assign unused_crit_rise = rises[2] ^ lock;

    temp_alarm_event u_event (
        .clk(clk), .rst_n(rst_n), .evt_en(cfg.evt_en), .int_mode(cfg.int_mode),
        .crit_only(cfg.crit_only), .win_en(cfg.win_en), .clr_p(clr_p),
        .above(flags[0]), .below(flags[1]), .crit(flags[2]),
        .above_rise(rises[0]), .below_rise(rises[1]), .evt_n(evt_n)
    );

    assign cond_status = flags;

endmodule

// File: tb/sim_temp_alarm_ctrl.sv
// Bench for temp_alarm_ctrl: a behavioural model steps on every edge and is compared each cycle.
module sim_temp_alarm_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_temp = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        evt_n;
    logic [2:0]  cond_status;

    int checks = 0, errors = 0;
    bit done = 0;
    string req = "R1";

    // model state
    int m_up, m_lo, m_cr, m_hc;
    bit m_en, m_int, m_co, m_win, m_lock, m_ab, m_be, m_cq, m_lat;

    temp_alarm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_n(evt_n), .cond_status(cond_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int s13(input logic [12:0] v);
        return int'($signed(v));
    endfunction

    function automatic int hyst_of(input int code);
        case (code)
            0: return 0;
            1: return 24;
            2: return 48;
            default: return 96;
        endcase
    endfunction

    task automatic model_step();
        int t, hy;
        bit clr, nab, nbe, ncq, r_ab, r_be, nlat;
        if (!rst_n) begin
            m_up = 4095; m_lo = -4096; m_cr = 4095; m_hc = 0;
            {m_en, m_int, m_co, m_win, m_lock, m_ab, m_be, m_cq, m_lat} = '0;
            return;
        end
        hy = hyst_of(m_hc);
        t = s13(smp_temp);
        clr = wr_en && wr_addr == 2'd0 && wr_data[6];
        nab = m_ab; nbe = m_be; ncq = m_cq; r_ab = 0; r_be = 0;
        if (smp_valid) begin
            if (m_ab) nab = !(t <= m_up - hy); else begin nab = t > m_up; r_ab = nab; end
            if (m_be) nbe = !(t >= m_lo + hy); else begin nbe = t < m_lo; r_be = nbe; end
            if (m_cq) ncq = !(t <= m_cr - hy); else ncq = t > m_cr;
        end
        nlat = (m_int && !m_co) ? ((m_win && (r_ab || r_be)) || (m_lat && !clr)) : 1'b0;
        if (wr_en) begin
            case (wr_addr)
                2'd0: begin
                    m_en = wr_data[0]; m_int = wr_data[1]; m_co = wr_data[2];
                    m_win = wr_data[3]; m_hc = int'(wr_data[5:4]);
                    if (wr_data[7]) m_lock = 1;
                end
                2'd1: m_up = s13(wr_data);
                2'd2: m_lo = s13(wr_data);
                default: if (!m_lock) m_cr = s13(wr_data);
            endcase
        end
        m_ab = nab; m_be = nbe; m_cq = ncq; m_lat = nlat;
    endtask

    task automatic compare();
        bit ev, exp_n;
        logic [2:0] exp_st;
        ev = m_co ? m_cq : (m_cq || (m_int ? m_lat : (m_win && (m_ab || m_be))));
        exp_n = !(m_en && ev);
        exp_st = {m_cq, m_be, m_ab};
        checks++;
        if (evt_n !== exp_n || cond_status !== exp_st) begin
            errors++;
            $display("FAIL %s: evt_n=%b status=%b expected evt_n=%b status=%b",
                     req, evt_n, cond_status, exp_n, exp_st);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [1:0] a, input logic [12:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic smp(input int t);
        smp_valid = 1; smp_temp = 13'(t);
        cyc();
        smp_valid = 0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        req = "R1"; cyc(); cyc();

        req = "R13"; wr(1, 400); wr(2, 80); wr(3, 1200);
        wr(0, 13'b0000_1001);                 // enable, compare, window, hyst 0

        req = "R2"; smp_valid = 0; smp_temp = 13'd500; cyc(); cyc();
        req = "R7"; smp(500); cyc();
        wr(0, 13'b0100_1001);                 // clear strobe: no effect in compare mode
        cyc(); smp(200); cyc();

        req = "R3"; wr(0, 13'b0010_1001);     // hyst 48
        smp(500); smp(380); smp(353); smp(352); cyc();

        req = "R4"; wr(0, 13'b0011_1001);     // hyst 96
        smp(50); smp(175); smp(176);
        wr(2, 13'h1F60);                      // lower -160
        smp(-200); smp(-65); smp(-64); smp(0);

        req = "R6"; wr(0, 13'b0001_1001);     // hyst 24
        smp(500); smp(377); smp(376);
        wr(2, 80);

        req = "R5"; wr(0, 13'b0010_1001);
        smp(1300); smp(1160); smp(1152); smp(200);

        req = "R8"; wr(0, 13'b0000_1011);     // interrupt mode, window on
        smp(500); smp(200); cyc(); cyc();
        wr(0, 13'b0100_1011); cyc();
        smp(50); smp(200); wr(0, 13'b0100_1011);
        wr(0, 13'b0000_0011);                 // window off: no latch
        smp(500); smp(200); cyc();
        wr(0, 13'b0000_1011);
        smp(500); smp_valid = 1; smp_temp = 13'd200;  // clear with a sample on the same edge
        wr(0, 13'b0100_1011); smp_valid = 0; cyc();

        req = "R9"; smp(1300); wr(0, 13'b0100_1011); cyc();
        smp(1100); cyc();

        req = "R10"; wr(0, 13'b0000_1101);    // critical-only
        smp(200); smp(600); smp(50); smp(1300); wr(0, 13'b0100_1101); cyc();

        req = "R11"; wr(0, 13'b0000_1100); cyc(); smp(200); cyc();

        req = "R12"; wr(0, 13'b1000_1101);    // lock
        wr(3, 2000); smp(1250); smp(1100); smp(1250);
        wr(0, 13'b0000_1101); wr(3, 2000); smp(1100); smp(1201); cyc();

        req = "R1"; rst_n = 0; cyc(); rst_n = 1; cyc();
        wr(3, 100); wr(0, 13'b0000_0101); smp(150); cyc();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule